// File: doc/BRIEF.md
# DMA Interrupt Coalescing Controller

This block sits beside the completion logic of a DMA engine. Instead of raising one interrupt for every finished packet, it gathers completions and raises one interrupt for the whole group. Each channel has its own instance, for example one for transmit and one for receive. Each instance counts the completion pulses reported by its channel. It flags a threshold event when the count reaches a programmable value. It flags a timeout event when a wait-bound timer runs out while completions are still unreported, so a short trailing burst is never left waiting.

Software sets the threshold and the wait bound of one channel in a single write. It sets the enable bits of all channels in a second kind of write. It clears status by writing back the bits it read (write-1-to-clear). A software reset puts the configuration back to its defaults and stops the channel. It does not touch the pending status. The wait-bound timer counts prescaled ticks. The prescaler divides the system clock by a build-time parameter, so one unit of wait bound can be set to about a millisecond.

Top module: `icoal_top`

## Requirements
- R1: After the hardware reset, every status bit and every interrupt output is 0, and every channel's enable is 0. The threshold and the wait bound are both 1, so a single completion on a channel sets that channel's threshold bit. A channel's threshold bit is status[2*ch]; its timeout bit is status[2*ch+1].
- R2: The threshold bit of a channel is set on the clock edge that samples the completion that brings the count since the last report up to the threshold, and not earlier. Raising it clears the count, so the next group counts from zero.
- R3: A threshold value of 0 behaves exactly like a threshold of 1.
- R4: The wait bound is W and the prescale factor is P. If a completion arrives while the channel's timer is idle and the threshold is not reached, the timeout bit is set between (W-1)*P+1 and W*P clock cycles after the edge that sampled that completion. A wait bound of 0 disables the timeout.
- R5: An acknowledge write restarts the running timer from zero. An acknowledge write is any ack bit of the channel at 1, and ack uses the same bit positions as status.
- R6: Status bits are sticky. An ack bit at 1 clears only the matching status bit. A new event in the same cycle wins over the clear.
- R7: irq[ch] is 1 exactly when the channel's enable is 1 and at least one of its two status bits is 1. Disabling the interrupt leaves the status bits unchanged.
- R8: A software reset returns the threshold and the wait bound to 1, clears the enables, the count and the timer, and leaves every status bit unchanged.
- R9: Completions, configuration writes and acks on one channel do not change the status of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sw_rst | input | 1 | Software reset pulse: configuration to defaults, status kept |
| cmp | input | NCH | One completion pulse per channel |
| wr_en | input | 1 | Write threshold and wait bound of channel wr_ch |
| wr_ch | input | CHW | Channel selected by a configuration write |
| wr_thr | input | CNT_W | Threshold value to write |
| wr_wb | input | WB_W | Wait bound, in prescaled ticks, to write |
| en_we | input | 1 | Write the interrupt enable of every channel |
| en_val | input | NCH | Enable values, one bit per channel |
| ack | input | 2*NCH | Write-1-to-clear mask, same layout as status |
| irq | output | NCH | Interrupt per channel |
| status | output | 2*NCH | Sticky bits: bit 2*ch threshold reached, bit 2*ch+1 timeout |

## Verification
The hardest case to reach from the ports is the timer restart caused by an acknowledge. The restart only shows when the acknowledge lands inside a running wait window. The prescaler phase is not visible, so the exact firing cycle is not known. The stimulus therefore starts the timer, acknowledges part-way through the window, and then checks two things. First, no timeout appears by a cycle that an unrestarted timer could not have passed. Second, the timeout does appear inside the window counted from the acknowledge. The same windowed latency measurement checks the plain wait bound for several values.

// File: rtl/icoal_pkg.sv
package icoal_pkg;

    // Sticky event bits of one channel: bit 0 threshold, bit 1 timeout
    typedef struct packed {
        logic tout;
        logic hit;
    } icoal_sts_t;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_WAIT = 1'b1
    } icoal_run_e;

    // Write-1-to-clear with set priority
    function automatic icoal_sts_t sts_next(icoal_sts_t cur, icoal_sts_t set, logic [1:0] clr);
        logic [1:0] v;
        v = (cur & ~clr) | set;
        return icoal_sts_t'(v);
    endfunction

endpackage

// File: rtl/icoal_tick.sv
module icoal_tick #(
    parameter int PRESCALE = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_rst,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pcnt;

    assign tick = (pcnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || sw_rst) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/icoal_chan.sv
module icoal_chan
    import icoal_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int WB_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_rst,
    input  logic             tick,
    input  logic             cmp,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_thr,
    input  logic [WB_W-1:0]  cfg_wb,
    input  logic             en_we,
    input  logic             en_val,
    input  logic [1:0]       ack,
    output icoal_sts_t       sts,
    output logic             irq
);
    localparam logic [CNT_W-1:0] THR_ONE = CNT_W'(1);
    localparam logic [WB_W-1:0]  WB_ONE  = WB_W'(1);

    logic [CNT_W-1:0] thr_q, cnt_q, eff_thr, cnt_inc;
    logic [WB_W-1:0]  wb_q, tmr_q;
    logic             en_q;
    icoal_run_e       run_q;
    icoal_sts_t       sts_q, set_v;
    logic             hit, wb_end, ack_any;

    always_comb begin
        eff_thr = (thr_q == '0) ? THR_ONE : thr_q;
        cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
        hit     = cmp && (cnt_inc >= eff_thr);
        wb_end  = (wb_q != '0) && (run_q == CH_WAIT) && tick && ((tmr_q + 1'b1) >= wb_q);
        ack_any = |ack;
        set_v.hit  = hit && !sw_rst;
        set_v.tout = wb_end && !hit && !sw_rst;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= THR_ONE;
            wb_q  <= WB_ONE;
            en_q  <= 1'b0;
            cnt_q <= '0;
            tmr_q <= '0;
            run_q <= CH_IDLE;
            sts_q <= '0;
        end else begin
            sts_q <= sts_next(sts_q, set_v, ack);
            if (sw_rst) begin
                thr_q <= THR_ONE;
                wb_q  <= WB_ONE;
                en_q  <= 1'b0;
                cnt_q <= '0;
                tmr_q <= '0;
                run_q <= CH_IDLE;
            end else begin
                if (cfg_we) begin
                    thr_q <= cfg_thr;
                    wb_q  <= cfg_wb;
                end
                if (en_we) begin
                    en_q <= en_val;
                end
                if (hit || wb_end) begin
                    cnt_q <= '0;
                    tmr_q <= '0;
                    run_q <= CH_IDLE;
                end else begin
                    if (cmp) begin
                        cnt_q <= cnt_inc;
                    end
                    if (cmp && run_q == CH_IDLE) begin
                        run_q <= CH_WAIT;
                        tmr_q <= '0;
                    end else if (ack_any) begin
                        tmr_q <= '0;
                    end else if (run_q == CH_WAIT && tick) begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
            end
        end
    end

    assign sts = sts_q;
    assign irq = en_q && (sts_q.hit || sts_q.tout);

    AST_HIT_AT_ONE: assert property (@(posedge clk) disable iff (rst)
        (cmp && !sw_rst && thr_q <= THR_ONE) |=> sts_q.hit); // R3
    AST_HIT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sts_q.hit && !ack[0]) |=> sts_q.hit); // R6
    AST_TOUT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sts_q.tout && !ack[1]) |=> sts_q.tout); // R6
    AST_TOUT_PENDING: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_q.tout) |-> $past(run_q == CH_WAIT)); // R4
    AST_SWRST_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        sw_rst |=> (thr_q == THR_ONE && wb_q == WB_ONE && !en_q)); // R8
    AST_SWRST_KEEPS_STS: assert property (@(posedge clk) disable iff (rst)
        (sw_rst && ack == 2'b00) |=> $stable(sts_q)); // R8

endmodule

// File: rtl/icoal_top.sv
module icoal_top
    import icoal_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int CNT_W    = 8,
    parameter int WB_W     = 8,
    parameter int PRESCALE = 100000,
    localparam int CHW     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sw_rst,
    input  logic [NCH-1:0]     cmp,
    input  logic               wr_en,
    input  logic [CHW-1:0]     wr_ch,
    input  logic [CNT_W-1:0]   wr_thr,
    input  logic [WB_W-1:0]    wr_wb,
    input  logic               en_we,
    input  logic [NCH-1:0]     en_val,
    input  logic [2*NCH-1:0]   ack,
    output logic [NCH-1:0]     irq,
    output logic [2*NCH-1:0]   status
);
    logic tick;

    icoal_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .sw_rst (sw_rst),
        .tick   (tick)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        icoal_sts_t sts_c;
        logic       cfg_we_c;

        assign cfg_we_c = wr_en && (wr_ch == CHW'(ch));

        icoal_chan #(.CNT_W(CNT_W), .WB_W(WB_W)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .sw_rst (sw_rst),
            .tick   (tick),
            .cmp    (cmp[ch]),
            .cfg_we (cfg_we_c),
            .cfg_thr(wr_thr),
            .cfg_wb (wr_wb),
            .en_we  (en_we),
            .en_val (en_val[ch]),
            .ack    (ack[2*ch +: 2]),
            .sts    (sts_c),
            .irq    (irq[ch])
        );

        assign status[2*ch +: 2] = sts_c;

        AST_CH_ISOLATED: assert property (@(posedge clk) disable iff (rst)
            (!cmp[ch] && !tick && ack[2*ch +: 2] == 2'b00) |=> status[2*ch +: 2] == $past(status[2*ch +: 2])); // R9
    end

endmodule

// File: tb/sim_icoal_top.sv
module sim_icoal_top;
    localparam int CLK_P = 10;
    localparam int NCH = 2;
    localparam int P   = 8;

    logic       clk = 1'b0;
    logic       rst, sw_rst, wr_en, en_we;
    logic [1:0] cmp, en_val, irq;
    logic [0:0] wr_ch;
    logic [7:0] wr_thr, wr_wb;
    logic [3:0] ack, status;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    icoal_top #(.NCH(NCH), .CNT_W(8), .WB_W(8), .PRESCALE(P)) u0 (
        .clk(clk), .rst(rst), .sw_rst(sw_rst), .cmp(cmp),
        .wr_en(wr_en), .wr_ch(wr_ch), .wr_thr(wr_thr), .wr_wb(wr_wb),
        .en_we(en_we), .en_val(en_val), .ack(ack),
        .irq(irq), .status(status)
    );

    // {threshold, pulses, expected threshold bit}, channel 0, timeout off
    localparam int NV = 7;
    localparam logic [16:0] VEC [NV] = '{
        {8'd1,   8'd1,  1'b1},
        {8'd3,   8'd2,  1'b0},
        {8'd3,   8'd3,  1'b1},
        {8'd0,   8'd1,  1'b1},
        {8'd5,   8'd4,  1'b0},
        {8'd200, 8'd12, 1'b0},
        {8'd2,   8'd2,  1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input int ch, input int thr, input int wb);
        wr_en = 1'b1; wr_ch = 1'(ch); wr_thr = 8'(thr); wr_wb = 8'(wb);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_en(input logic [1:0] v);
        en_we = 1'b1; en_val = v;
        @(negedge clk);
        en_we = 1'b0;
    endtask

    task automatic pulse(input int ch);
        cmp[ch] = 1'b1;
        @(negedge clk);
        cmp = '0;
    endtask

    task automatic do_ack(input logic [3:0] m);
        ack = m;
        @(negedge clk);
        ack = '0;
    endtask

    task automatic swr;
        sw_rst = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0;
    endtask

    task automatic clean;
        swr();
        do_ack(4'hF);
    endtask

    // cycles after the last sampling edge until status[idx] is seen
    task automatic wait_bit(input int idx, input int lim, output int c);
        c = 0;
        while (status[idx] !== 1'b1 && c < lim) begin
            @(negedge clk);
            c++;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int c;
        rst = 1'b1; sw_rst = 1'b0; cmp = '0; wr_en = 1'b0; wr_ch = '0;
        wr_thr = '0; wr_wb = '0; en_we = 1'b0; en_val = '0; ack = '0;
        cyc(4);
        rst = 1'b0;
        cyc(1);

        // R1 reset state and defaults
        chk("R1 status", 32'(status), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        pulse(1);
        chk("R1 default threshold ch1", 32'(status), 32'h4);
        chk("R1 enable off", 32'(irq), 32'h0);
        set_en(2'b11);
        chk("R7 enable exposes status", 32'(irq), 32'h2);
        pulse(0);
        chk("R1 default threshold ch0", 32'(status), 32'h5);
        chk("R7 irq both", 32'(irq), 32'h3);
        do_ack(4'hF);
        chk("R6 clear all", 32'(status), 32'h0);
        chk("R7 irq low when clear", 32'(irq), 32'h0);

        // R2 R3 vector table
        for (int i = 0; i < NV; i++) begin
            clean();
            cfg(0, int'(VEC[i][16:9]), 0);
            for (int k = 0; k < int'(VEC[i][8:1]); k++) pulse(0);
            chk($sformatf("R2/R3 vec %0d", i), 32'(status[0]), 32'(VEC[i][0]));
        end

        // R2 count restarts after a report, not early
        clean();
        cfg(0, 3, 0);
        pulse(0); pulse(0);
        chk("R2 below threshold", 32'(status[0]), 32'h0);
        pulse(0);
        chk("R2 at threshold", 32'(status[0]), 32'h1);
        do_ack(4'h1);
        pulse(0); pulse(0);
        chk("R2 count cleared after report", 32'(status[0]), 32'h0);
        pulse(0);
        chk("R2 next group", 32'(status[0]), 32'h1);

        // R4 timeout windows
        clean();
        cfg(0, 20, 1);
        pulse(0);
        wait_bit(1, 40, c);
        chk("R4 wb1 fired", 32'(status[1]), 32'h1);
        chk("R4 wb1 window", 32'(c >= 1 && c <= P), 32'h1);
        clean();
        cfg(0, 20, 2);
        pulse(0);
        wait_bit(1, 60, c);
        chk("R4 wb2 window", 32'(c >= P + 1 && c <= 2 * P), 32'h1);
        clean();
        cfg(0, 20, 0);
        pulse(0);
        cyc(100);
        chk("R4 wb0 never times out", 32'(status), 32'h0);

        // R5 acknowledge restarts the timer
        clean();
        cfg(0, 20, 3);
        pulse(0);
        cyc(12);
        do_ack(4'h3);
        cyc(16);
        chk("R5 no timeout before restarted window", 32'(status[1]), 32'h0);
        wait_bit(1, 20, c);
        chk("R5 timeout after restart", 32'(status[1]), 32'h1);
        chk("R5 restart window", 32'(c >= 1 && c <= 8), 32'h1);

        // R6 selective write-1-to-clear
        clean();
        cfg(0, 2, 1);
        pulse(0);
        cyc(10);
        chk("R6 timeout only", 32'(status[1:0]), 32'h2);
        pulse(0); pulse(0);
        chk("R6 both bits", 32'(status[1:0]), 32'h3);
        do_ack(4'h1);
        chk("R6 clear hit only", 32'(status[1:0]), 32'h2);
        do_ack(4'h2);
        chk("R6 clear timeout", 32'(status[1:0]), 32'h0);

        // R8 software reset keeps status, restores defaults
        clean();
        set_en(2'b01);
        cfg(0, 1, 0);
        pulse(0);
        chk("R8 setup", 32'(irq), 32'h1);
        cfg(0, 5, 0);
        swr();
        chk("R8 status kept", 32'(status), 32'h1);
        chk("R8 enable cleared", 32'(irq), 32'h0);
        do_ack(4'hF);
        set_en(2'b01);
        pulse(0);
        chk("R8 threshold back to 1", 32'(status), 32'h1);
        chk("R8 enable rewritable", 32'(irq), 32'h1);

        // R9 channels independent
        clean();
        cfg(1, 2, 0);
        cfg(0, 1, 0);
        pulse(0); pulse(0);
        chk("R9 ch1 untouched", 32'(status), 32'h1);
        pulse(1);
        chk("R9 ch1 own threshold", 32'(status), 32'h1);
        pulse(1);
        chk("R9 ch1 reached", 32'(status), 32'h5);
        do_ack(4'h1);
        chk("R9 ack ch0 only", 32'(status), 32'h4);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule